// File: doc/BRIEF.md
# Burst-of-Two Double-Data-Rate Synchronous SRAM Model

This block is a synthesizable behavioural model of a synchronous static RAM with a double-data-rate data port. Every transfer is a burst of two words. On each rising clock edge it samples an active-low start strobe, a read/write select and an address. A write takes its two words one cycle after the command. A read returns its two words after a latency that depends on the clock-recovery mode. Each half-cycle of the data port is carried on its own bus: a rise-phase word and a fall-phase word. Because of this, the whole model runs in a single clock domain and fits into a larger simulation or an FPGA prototype.

The burst always covers an aligned pair of words. The even word travels on the rise-phase bus and the odd word on the fall-phase bus. A clock-stop input freezes the model and holds its outputs. A lock indicator reports when the clock-recovery loop is locked. The loop needs a run of uninterrupted clock cycles while it is enabled. When the loop is disabled, the model runs in a reduced mode with a shorter read latency.

Top module: `ddr_burst_sram`

## Requirements
- R1: While `rst` is high, and in the first cycle after it, `rdata_oe` and `locked` are both low.
- R2: A command is accepted on an edge where `start_n` is low, `rd_sel` is low and `stop_clk` is low. On the next active edge, `wdata_rise` is stored at the even address of the pair and `wdata_fall` at the odd address.
- R3: A read is accepted on an edge where `start_n` is low and `rd_sel` is high, with `dll_enable` high. Two active edges later, `rdata_oe` goes high for one cycle. In that cycle `rdata_rise` carries the even word and `rdata_fall` the odd word.
- R4: Address bit 0 of a command is ignored: a burst always covers the pair {addr[ADDR_W-1:1],0} and {addr[ADDR_W-1:1],1}.
- R5: With `dll_enable` low, read data and `rdata_oe` appear one active edge after the read command instead of two.
- R6: In any cycle that carries no read data, `rdata_oe` is low. This covers no-operation cycles, where `start_n` is high, and write cycles.
- R7: Commands are accepted on back-to-back edges. A read issued one cycle after a write to the same pair returns the newly written words.
- R8: While `stop_clk` is high, `rdata_oe`, `rdata_rise` and `rdata_fall` hold their values. Commands and write data are ignored, and transfers already in flight resume where they stopped.
- R9: `locked` goes high once `dll_enable` has been high and `stop_clk` low for LOCK_CYCLES (default 2048) consecutive edges. It goes low, and the count restarts, on any edge with `dll_enable` low or `stop_clk` high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Main clock; every register uses its rising edge |
| rst | input | 1 | Synchronous active-high reset |
| stop_clk | input | 1 | High models a stopped clock; all state is frozen |
| dll_enable | input | 1 | High: clock-recovery loop on, read latency 2; low: reduced mode, read latency 1 |
| start_n | input | 1 | Active-low command strobe |
| rd_sel | input | 1 | Command type: 1 read, 0 write |
| addr | input | ADDR_W | Command address; bit 0 ignored |
| wdata_rise | input | DATA_W | Write word for the even address, one cycle after the command |
| wdata_fall | input | DATA_W | Write word for the odd address, one cycle after the command |
| rdata_rise | output | DATA_W | Read word from the even address |
| rdata_fall | output | DATA_W | Read word from the odd address |
| rdata_oe | output | 1 | High in the cycle read data is valid; low means the bus would float |
| locked | output | 1 | Clock-recovery lock indication |

## Verification
A read command sampled at edge n produces its data and `rdata_oe` just after edge n+2 in normal mode, or just after edge n+1 in reduced mode. Write data belongs to edge n+1. The bench numbers active edges and computes the due edge for each read when it issues the read. Edges during a clock stop are not counted, so these due edges stay correct across a stop. The bench drives inputs and compares outputs only on falling edges, one half-cycle after the edge that produced them. The lock count is modelled edge by edge and compared every cycle.

// File: rtl/ddrb_pkg.sv
package ddrb_pkg;
  typedef struct packed {
    logic valid;
    logic is_rd;
  } ddrb_op_t;
endpackage

// File: rtl/ddrb_cmd_pipe.sv
module ddrb_cmd_pipe
  import ddrb_pkg::*;
#(
  parameter int PAIR_W = 9
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              adv,
  input  logic              start_n,
  input  logic              rd_sel,
  input  logic [PAIR_W-1:0] pair_in,
  output ddrb_op_t          op1,
  output ddrb_op_t          op2,
  output logic [PAIR_W-1:0] pa1,
  output logic [PAIR_W-1:0] pa2
);
  always_ff @(posedge clk) begin
    if (rst) begin
      op1 <= '0;
      op2 <= '0;
    end else if (adv) begin
      op1.valid <= !start_n;
      op1.is_rd <= rd_sel;
      op2       <= op1;
    end
  end

  always_ff @(posedge clk) begin
    if (adv) begin
      pa1 <= pair_in;
      pa2 <= pa1;
    end
  end
endmodule

// File: rtl/ddrb_store.sv
module ddrb_store #(
  parameter int PAIR_W = 9,
  parameter int DATA_W = 18
) (
  input  logic              clk,
  input  logic              adv,
  input  logic              we,
  input  logic [PAIR_W-1:0] waddr,
  input  logic [DATA_W-1:0] wd_rise,
  input  logic [DATA_W-1:0] wd_fall,
  input  logic              re,
  input  logic [PAIR_W-1:0] raddr,
  output logic [DATA_W-1:0] q_rise,
  output logic [DATA_W-1:0] q_fall
);
  localparam int DEPTH = 1 << PAIR_W;
  localparam int ROW_W = 2 * DATA_W;

  logic [ROW_W-1:0] mem [0:DEPTH-1];
  logic [ROW_W-1:0] q_row;

  always_ff @(posedge clk) begin
    if (adv && we) mem[waddr] <= {wd_fall, wd_rise};
  end

  always_ff @(posedge clk) begin
    if (adv && re) q_row <= mem[raddr];
  end

  assign q_rise = q_row[DATA_W-1:0];
  assign q_fall = q_row[ROW_W-1:DATA_W];
endmodule

// File: rtl/ddrb_lock.sv
module ddrb_lock #(
  parameter int LOCK_CYCLES = 2048
) (
  input  logic clk,
  input  logic rst,
  input  logic dll_enable,
  input  logic stop_clk,
  output logic locked
);
  localparam int CW = $clog2(LOCK_CYCLES + 1);
  localparam logic [CW-1:0] LIMIT = CW'(LOCK_CYCLES);

  logic [CW-1:0] cnt;

  always_ff @(posedge clk) begin
    if (rst || !dll_enable || stop_clk) cnt <= '0;
    else if (cnt != LIMIT)              cnt <= cnt + 1'b1;
  end

  assign locked = (cnt == LIMIT);
endmodule

// File: rtl/ddr_burst_sram.sv
module ddr_burst_sram
  import ddrb_pkg::*;
#(
  parameter int ADDR_W      = 10,
  parameter int DATA_W      = 18,
  parameter int LOCK_CYCLES = 2048
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              stop_clk,
  input  logic              dll_enable,
  input  logic              start_n,
  input  logic              rd_sel,
  input  logic [ADDR_W-1:0] addr,
  input  logic [DATA_W-1:0] wdata_rise,
  input  logic [DATA_W-1:0] wdata_fall,
  output logic [DATA_W-1:0] rdata_rise,
  output logic [DATA_W-1:0] rdata_fall,
  output logic              rdata_oe,
  output logic              locked
);
  localparam int PAIR_W = ADDR_W - 1;

  logic              adv;
  ddrb_op_t          op1, op2;
  logic [PAIR_W-1:0] pa1, pa2;
  logic              we, re;
  logic [PAIR_W-1:0] raddr;

  assign adv = !stop_clk;

  ddrb_cmd_pipe #(.PAIR_W(PAIR_W)) u_pipe (
    .clk(clk), .rst(rst), .adv(adv), .start_n(start_n), .rd_sel(rd_sel),
    .pair_in(addr[ADDR_W-1:1]), .op1(op1), .op2(op2), .pa1(pa1), .pa2(pa2)
  );

  // write data belongs to the cycle after the command; read point set by mode
  assign we    = op1.valid && !op1.is_rd;
  assign re    = dll_enable ? (op2.valid && op2.is_rd) : (op1.valid && op1.is_rd);
  assign raddr = dll_enable ? pa2 : pa1;

  ddrb_store #(.PAIR_W(PAIR_W), .DATA_W(DATA_W)) u_store (
    .clk(clk), .adv(adv), .we(we), .waddr(pa1),
    .wd_rise(wdata_rise), .wd_fall(wdata_fall),
    .re(re), .raddr(raddr), .q_rise(rdata_rise), .q_fall(rdata_fall)
  );

  always_ff @(posedge clk) begin
    if (rst)      rdata_oe <= 1'b0;
    else if (adv) rdata_oe <= re;
  end

  ddrb_lock #(.LOCK_CYCLES(LOCK_CYCLES)) u_lock (
    .clk(clk), .rst(rst), .dll_enable(dll_enable), .stop_clk(stop_clk),
    .locked(locked)
  );
endmodule

// File: rtl/ddrb_checker.sv
module ddrb_checker #(
  parameter int DATA_W = 18
) (
  input logic              clk,
  input logic              rst,
  input logic              stop_clk,
  input logic              dll_enable,
  input logic              start_n,
  input logic              rd_sel,
  input logic [DATA_W-1:0] rdata_rise,
  input logic [DATA_W-1:0] rdata_fall,
  input logic              rdata_oe,
  input logic              locked
);
  assert_reset_quiet_R1: assert property (@(posedge clk)
    rst |=> (!rdata_oe && !locked));

  assert_read_lat2_R3: assert property (@(posedge clk) disable iff (rst)
    (!start_n && rd_sel && !stop_clk && dll_enable)
    ##1 (!stop_clk && dll_enable) ##1 (!stop_clk && dll_enable) |=> rdata_oe);

  assert_read_lat1_R5: assert property (@(posedge clk) disable iff (rst)
    (!start_n && rd_sel && !stop_clk && !dll_enable)
    ##1 (!stop_clk && !dll_enable) |=> rdata_oe);

  assert_stop_holds_R8: assert property (@(posedge clk) disable iff (rst)
    (stop_clk && !rst) |=> ($stable(rdata_oe) && $stable(rdata_rise) && $stable(rdata_fall)));

  assert_lock_drop_R9: assert property (@(posedge clk) disable iff (rst)
    (!dll_enable || stop_clk) |=> !locked);

  assert_lock_rise_R9: assert property (@(posedge clk) disable iff (rst)
    $rose(locked) |-> ($past(dll_enable) && !$past(stop_clk)));
endmodule

bind ddr_burst_sram ddrb_checker #(.DATA_W(DATA_W)) u_chk (
  .clk(clk), .rst(rst), .stop_clk(stop_clk), .dll_enable(dll_enable),
  .start_n(start_n), .rd_sel(rd_sel), .rdata_rise(rdata_rise),
  .rdata_fall(rdata_fall), .rdata_oe(rdata_oe), .locked(locked)
);

// File: tb/sim_ddr_burst_sram.sv
module sim_ddr_burst_sram;
  localparam int CLK_P = 10;
  localparam int AW    = 10;
  localparam int DW    = 18;
  localparam int LOCKN = 2048;

  logic          clk = 1'b0;
  logic          rst = 1'b1;
  logic          stop_clk = 1'b0;
  logic          dll_enable = 1'b1;
  logic          start_n = 1'b1;
  logic          rd_sel = 1'b0;
  logic [AW-1:0] addr = '0;
  logic [DW-1:0] wdata_rise = '0;
  logic [DW-1:0] wdata_fall = '0;
  logic [DW-1:0] rdata_rise, rdata_fall;
  logic          rdata_oe, locked;

  always #(CLK_P/2) clk = ~clk;

  ddr_burst_sram #(.ADDR_W(AW), .DATA_W(DW), .LOCK_CYCLES(LOCKN)) u0 (
    .clk(clk), .rst(rst), .stop_clk(stop_clk), .dll_enable(dll_enable),
    .start_n(start_n), .rd_sel(rd_sel), .addr(addr),
    .wdata_rise(wdata_rise), .wdata_fall(wdata_fall),
    .rdata_rise(rdata_rise), .rdata_fall(rdata_fall),
    .rdata_oe(rdata_oe), .locked(locked)
  );

  int n_cmp = 0;
  int n_bad = 0;
  bit done  = 0;
  int cyc   = 0;
  int lk    = 0;

  logic [DW-1:0] ref_mem [0:(1<<AW)-1];
  bit            exp_v [int];
  logic [DW-1:0] exp_r [int];
  logic [DW-1:0] exp_f [int];
  bit            pw = 0;
  logic [DW-1:0] pw_r, pw_f;

  task automatic chk(input bit ok, input string tag, input logic [63:0] act, input logic [63:0] expv);
    n_cmp++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s at edge %0d: actual %0h expected %0h", tag, cyc, act, expv);
    end
  endtask

  task automatic lock_model();
    if (rst || !dll_enable || stop_clk) lk = 0;
    else if (lk < LOCKN) lk++;
  endtask

  task automatic check_all(input string tag);
    bit e;
    e = exp_v.exists(cyc);
    chk(rdata_oe === e, {tag, " R6 oe"}, 64'(rdata_oe), 64'(e));
    if (e) begin
      chk(rdata_rise === exp_r[cyc], {tag, " rise"}, 64'(rdata_rise), 64'(exp_r[cyc]));
      chk(rdata_fall === exp_f[cyc], {tag, " fall"}, 64'(rdata_fall), 64'(exp_f[cyc]));
    end
    chk(locked === (lk >= LOCKN), {tag, " R9 locked"}, 64'(locked), 64'(lk >= LOCKN));
  endtask

  task automatic tick(input bit cmd, input bit rd, input logic [AW-1:0] a, input string tag);
    logic [DW-1:0] d0, d1;
    logic [AW-1:0] ev, od;
    int k;
    d0 = DW'($urandom);
    d1 = DW'($urandom);
    ev = {a[AW-1:1], 1'b0};
    od = {a[AW-1:1], 1'b1};
    start_n = !cmd;
    rd_sel  = rd;
    addr    = a;
    if (pw) begin
      wdata_rise = pw_r;
      wdata_fall = pw_f;
      pw = 0;
    end else begin
      wdata_rise = DW'($urandom);
      wdata_fall = DW'($urandom);
    end
    if (cmd && !rd) begin
      pw = 1; pw_r = d0; pw_f = d1;
      ref_mem[ev] = d0;
      ref_mem[od] = d1;
    end
    if (cmd && rd) begin
      k = cyc + (dll_enable ? 3 : 2);
      exp_v[k] = 1;
      exp_r[k] = ref_mem[ev];
      exp_f[k] = ref_mem[od];
    end
    @(posedge clk);
    cyc++;
    lock_model();
    @(negedge clk);
    check_all(tag);
  endtask

  task automatic nops(input int n, input string tag);
    for (int i = 0; i < n; i++) tick(0, 0, '0, tag);
  endtask

  task automatic stop_for(input int n);
    logic          h_oe;
    logic [DW-1:0] h_r, h_f;
    h_oe = rdata_oe; h_r = rdata_rise; h_f = rdata_fall;
    stop_clk = 1;
    start_n  = 0;
    rd_sel   = 1;
    for (int i = 0; i < n; i++) begin
      @(posedge clk);
      lock_model();
      @(negedge clk);
      chk(rdata_oe === h_oe, "R8 oe hold", 64'(rdata_oe), 64'(h_oe));
      chk(rdata_rise === h_r, "R8 rise hold", 64'(rdata_rise), 64'(h_r));
      chk(rdata_fall === h_f, "R8 fall hold", 64'(rdata_fall), 64'(h_f));
      chk(locked === 1'b0, "R9 locked in stop", 64'(locked), 64'(0));
    end
    stop_clk = 0;
    start_n  = 1;
  endtask

  task automatic finish_run();
    if (!done) begin
      done = 1;
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
      $finish;
    end
  endtask

  initial begin
    #(CLK_P * 200000);
    n_cmp++;
    n_bad++;
    $display("FAIL watchdog expired: actual running expected finished");
    finish_run();
  end

  initial begin
    logic [AW-1:0] wa [8];
    logic [AW-1:0] a;
    repeat (3) @(posedge clk);
    @(negedge clk);
    chk(rdata_oe === 1'b0, "R1 oe in reset", 64'(rdata_oe), 64'(0));
    chk(locked === 1'b0, "R1 locked in reset", 64'(locked), 64'(0));
    rst = 0;
    lk  = 0;
    tick(0, 0, '0, "R1");

    // R2 R4: bursts written, read back with bit 0 flipped
    for (int i = 0; i < 8; i++) begin
      wa[i] = AW'(8 * i + ($urandom % 8));
      tick(1, 0, wa[i], "R2 write");
    end
    nops(2, "R6 idle");
    for (int i = 0; i < 8; i++) tick(1, 1, wa[i] ^ AW'(1), "R3 R4 read");
    nops(3, "R6 idle");
    for (int i = 0; i < 4; i++) begin
      tick(1, 1, wa[i], "R3 spaced read");
      nops(2, "R6 gap");
    end

    // R7 read right after write to the same pair
    for (int i = 0; i < 4; i++) begin
      a = AW'($urandom);
      tick(1, 0, a, "R7 write");
      tick(1, 1, a, "R7 read");
    end
    nops(3, "R6 idle");

    // R8 stop while a read is in flight, with ignored commands
    a = AW'($urandom);
    tick(1, 0, a, "R8 write");
    tick(1, 1, a, "R8 read");
    stop_for(5);
    nops(4, "R8 resume");
    tick(1, 1, a, "R8 read2");
    tick(0, 0, '0, "R8");
    stop_for(3);
    nops(4, "R8 resume");

    // R9 lock after a run of clean edges
    nops(LOCKN + 20, "R9 count");

    // R5 reduced mode
    dll_enable = 0;
    nops(3, "R9 R5 mode change");
    for (int i = 0; i < 4; i++) tick(1, 1, wa[i], "R5 read");
    nops(2, "R6 idle");
    for (int i = 0; i < 4; i++) begin
      a = AW'($urandom);
      tick(1, 0, a, "R5 R7 write");
      tick(1, 1, a ^ AW'(1), "R5 R7 read");
    end
    nops(3, "R6 idle");
    dll_enable = 1;
    nops(3, "R9 mode back");

    // R9 restart on a stop
    nops(1000, "R9 partial");
    stop_for(2);
    nops(LOCKN + 10, "R9 restart");
    for (int i = 0; i < 2; i++) tick(1, 1, wa[i], "R3 read locked");
    nops(4, "R6 idle");
    finish_run();
  end
endmodule